// File: doc/BRIEF.md
# Packed Sample Output Serializer

This block turns a stream of 32-bit words into a steady stream of samples on a parallel output bus, one sample per sample tick, for a resistor-ladder digital-to-analog converter outside the chip. The sample width is fixed by a parameter. Each word carries as many whole samples as fit in 32 bits, and any leftover high bits are discarded. Words enter through a valid/ready port into a small queue. The queue holds four words in the normal mode and eight words when the deep mode is selected.

An integer divider sets the output rate. With a divide value of N, a sample tick occurs every N+1 clock cycles, so the output can run at any rate from full clock speed down to 1/65536 of it. When a word runs out of samples, the next tick reads the following word from the queue at once, so the output has no gap between words. If the queue is empty at that point, the output pins keep the last sample and a sticky underrun flag is raised. Output pins above the sample width are always driven low.

Top module: `packed_sample_serializer`

## Requirements
- R1: A word carries floor(32 / SAMPLE_W) samples: 4 at 8 bits, 3 at 10 bits, 2 at 11 or 12 bits, 1 above 16 bits. The word bits above the last whole sample never reach the output.
- R2: Samples leave a word starting from the least significant end. Slot k is word bits [k*SAMPLE_W +: SAMPLE_W].
- R3: Each sample tick puts exactly one new sample on the output, including the tick that moves on to a fresh word. Between ticks the output does not change.
- R4: A word is taken from the queue only when every sample of the previous word has been sent. Words are sent in the order they were accepted.
- R5: The queue accepts 4 words when cfg_join is 0 and 8 words when cfg_join is 1. in_ready is low while the queue is full, and a word offered while in_ready is low is discarded.
- R6: A sample tick occurs every cfg_div+1 clock cycles. Counting from the first clock edge after reset as edge 0, ticks fall on edges cfg_div, 2*cfg_div+1, and so on. cfg_div = 65535 gives a factor of 65536.
- R7: If a tick needs a new word and the queue is empty, the output holds the last sample and underrun goes high. underrun then stays high until reset, even after data arrives again. It is never raised before the first word has been sent.
- R8: Output bits from SAMPLE_W up to OUT_W-1 are always 0.
- R9: While rst_n is low at a clock edge, the queue is emptied, the output, underrun and the partial word are cleared, and the divider restarts. After reset, in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_div | input | DIV_W | Divide value: tick period is cfg_div+1 cycles |
| cfg_join | input | 1 | 1 selects the doubled queue depth |
| in_word | input | 32 | Packed sample word |
| in_valid | input | 1 | in_word is offered |
| in_ready | output | 1 | Queue has room for a word |
| out_sample | output | OUT_W | Sample bus to the converter |
| underrun | output | 1 | Sticky: a tick found no word to send |

## Verification
The bench builds two instances on the same clock. The first uses SAMPLE_W=8 and OUT_W=16, which gives four slots per word with the top half of the bus unused. The second uses SAMPLE_W=10 and OUT_W=16, which gives three slots per word with two dropped bits. The 8-bit instance covers the 4-deep and 8-deep queue limits, a divide value of zero (one sample every cycle) and the maximum divide value of 65535. The 10-bit instance shows that the two top bits of each word never reach the pins, and that the move to a new word still comes without a gap when a word holds an odd number of slots.

// File: rtl/pss_pkg.sv
// Shared constants and helpers for the packed sample serializer.
// Assumes every word on the input side is 32 bits wide.
package pss_pkg;
    localparam int WORD_W = 32;

    // Number of whole samples of width sw that fit in one word.
    function automatic int slots_per_word(input int sw);
        return WORD_W / sw;
    endfunction
endpackage

// File: rtl/pss_rate_divider.sv
// Integer rate divider: produces a one-cycle tick every cfg_div+1 cycles.
// Assumes cfg_div is held stable while running; the count restarts at reset.
module pss_rate_divider #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // Tick when the count has reached the divide value.
    always_comb tick = (cnt == cfg_div);

    // Count up, wrap to zero on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // R6: a nonzero divide value never yields two adjacent ticks.
    a_r6_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cfg_div != '0) |=> (!tick || cfg_div == '0));
endmodule

// File: rtl/pss_word_fifo.sv
// Word queue with storage for 2*BASE_DEPTH words. cfg_join selects whether
// BASE_DEPTH or all 2*BASE_DEPTH entries may be filled.
// Assumes BASE_DEPTH is a power of two and cfg_join changes only while idle.
module pss_word_fifo #(
    parameter int BASE_DEPTH = 4,
    parameter int WORD_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_join,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              pop,
    output logic [WORD_W-1:0] head,
    output logic              head_valid
);
    localparam int MAX_D = 2 * BASE_DEPTH;
    localparam int AW    = $clog2(MAX_D);
    localparam int CW    = $clog2(MAX_D + 1);
    localparam logic [CW-1:0] BASE_C = CW'(BASE_DEPTH);
    localparam logic [CW-1:0] MAX_C  = CW'(MAX_D);

    logic [WORD_W-1:0] mem [MAX_D];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     cnt;
    logic [CW-1:0]     cap;
    logic              push;

    // Capacity limit chosen by the depth mode, and the handshake.
    always_comb begin
        cap        = cfg_join ? MAX_C : BASE_C;
        in_ready   = (cnt < cap);
        push       = in_valid && in_ready;
        head       = mem[rd_ptr];
        head_valid = (cnt != '0);
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= in_word;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            unique case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R5: normal mode never holds more than BASE_DEPTH words.
    a_r5_base_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_join && cnt <= BASE_C) |=> (cnt <= BASE_C));
    // R5: occupancy never exceeds the storage.
    a_r5_max_cap: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= MAX_C);
    // R5: a word offered while full does not raise the occupancy.
    a_r5_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready && !pop) |=> $stable(cnt));
    // R4: the consumer pops only when a word is held.
    a_r4_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt != '0));
endmodule

// File: rtl/pss_unpacker.sv
// Unpacks SAMPLE_W-bit slots from a word, low slot first, one per tick.
// When the current word is used up, the same tick pops the queue head and
// sends its slot 0. With no head, the sample is held and underrun is set
// (only once a first word has been sent). Assumes SAMPLE_W <= WORD_W.
module pss_unpacker #(
    parameter int SAMPLE_W = 8,
    parameter int WORD_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [WORD_W-1:0]   head,
    input  logic                head_valid,
    output logic                pop,
    output logic [SAMPLE_W-1:0] sample,
    output logic                underrun
);
    localparam int SPW = pss_pkg::slots_per_word(SAMPLE_W);
    localparam int RW  = $clog2(SPW + 1);

    logic [WORD_W-1:0] shreg;
    logic [RW-1:0]     rem;
    logic              started;

    // Take a new word only when no slot is left and one is waiting.
    always_comb pop = tick && (rem == '0) && head_valid;

    // Shift state, output sample and the sticky underrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            rem      <= '0;
            sample   <= '0;
            started  <= 1'b0;
            underrun <= 1'b0;
        end else if (tick) begin
            if (rem != '0) begin
                sample <= shreg[SAMPLE_W-1:0];
                shreg  <= shreg >> SAMPLE_W;
                rem    <= rem - 1'b1;
            end else if (head_valid) begin
                sample  <= head[SAMPLE_W-1:0];
                shreg   <= head >> SAMPLE_W;
                rem     <= RW'(SPW - 1);
                started <= 1'b1;
            end else if (started) begin
                underrun <= 1'b1;
            end
        end
    end

    // R7: once raised, underrun stays up until reset.
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);
    // R7: the edge that raises underrun leaves the sample unchanged.
    a_r7_hold_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> $stable(sample));
    // R4: a word is never popped while slots of the previous one remain.
    a_r4_drain_first: assert property (@(posedge clk) disable iff (!rst_n)
        (rem != '0) |-> !pop);
endmodule

// File: rtl/packed_sample_serializer.sv
// Top level: word queue, rate divider and slot unpacker. Drives OUT_W pins,
// the low SAMPLE_W of them carry the sample and the rest are tied low.
// Assumes SAMPLE_W <= OUT_W and SAMPLE_W <= 32.
module packed_sample_serializer #(
    parameter int SAMPLE_W   = 8,
    parameter int OUT_W      = 16,
    parameter int BASE_DEPTH = 4,
    parameter int DIV_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_join,
    input  logic [31:0]      in_word,
    input  logic             in_valid,
    output logic             in_ready,
    output logic [OUT_W-1:0] out_sample,
    output logic             underrun
);
    localparam int WW = pss_pkg::WORD_W;

    logic                tick;
    logic                pop;
    logic [WW-1:0]       head;
    logic                head_valid;
    logic [SAMPLE_W-1:0] sample;

    pss_rate_divider #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_div (cfg_div),
        .tick    (tick)
    );

    pss_word_fifo #(.BASE_DEPTH(BASE_DEPTH), .WORD_W(WW)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_join   (cfg_join),
        .in_word    (in_word),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .pop        (pop),
        .head       (head),
        .head_valid (head_valid)
    );

    pss_unpacker #(.SAMPLE_W(SAMPLE_W), .WORD_W(WW)) u_unpack (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .head       (head),
        .head_valid (head_valid),
        .pop        (pop),
        .sample     (sample),
        .underrun   (underrun)
    );

    // Place the sample on the low pins, drive the unused pins low.
    always_comb begin
        out_sample                 = '0;
        out_sample[SAMPLE_W-1:0]   = sample;
    end

    // R3: the pins change only on a sample tick.
    a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(out_sample));
endmodule

// File: tb/packed_sample_serializer_tb.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checks its own results.
module packed_sample_serializer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_div = '0;
    logic        cfg_join = 1'b0;
    logic [31:0] in_word = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] out_sample;
    logic        underrun;
    logic [31:0] in10_word = '0;
    logic        in10_valid = 1'b0;
    logic        in10_ready;
    logic [15:0] out10;
    logic        und10;

    int total = 0;
    int bad = 0;
    int ecount = -1;
    int cur_div = 0;
    bit done = 1'b0;
    logic [31:0] wq [8];

    always #4 clk = ~clk;

    packed_sample_serializer #(.SAMPLE_W(8), .OUT_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_join(cfg_join),
        .in_word(in_word), .in_valid(in_valid), .in_ready(in_ready),
        .out_sample(out_sample), .underrun(underrun));

    packed_sample_serializer #(.SAMPLE_W(10), .OUT_W(16)) u_dut_w10 (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_join(cfg_join),
        .in_word(in10_word), .in_valid(in10_valid), .in_ready(in10_ready),
        .out_sample(out10), .underrun(und10));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input int d, input bit j);
        @(negedge clk);
        rst_n = 1'b0; cfg_div = 16'(d); cfg_join = j;
        in_valid = 1'b0; in10_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; ecount = -1; cur_div = d;
    endtask

    task automatic step();
        @(posedge clk); ecount++; @(negedge clk);
    endtask

    function automatic bit is_tick(input int e);
        return (cur_div == 0) || ((e % (cur_div + 1)) == cur_div);
    endfunction

    task automatic wait_tick();
        do step(); while (!is_tick(ecount));
    endtask

    function automatic logic [31:0] slot8(input int t);
        return 32'((wq[t / 4] >> (8 * (t % 4))) & 32'hFF);
    endfunction

    // R9 and R7: state after reset, no underrun before any word.
    task automatic t_reset();
        do_reset(0, 1'b0);
        repeat (5) step();
        check("R9 out after reset", 32'(out_sample), 32'h0);
        check("R9 ready after reset", 32'(in_ready), 32'h1);
        check("R7 no underrun before first word", 32'(underrun), 32'h0);
    endtask

    // R2 R3 R4 R7: stream n words at a divide value, then underrun hold.
    task automatic t_stream(input int d, input int n, input bit resume);
        do_reset(d, 1'b0);
        fork
            begin
                for (int i = 0; i < n; i++) begin
                    in_valid = 1'b1; in_word = wq[i];
                    @(posedge clk); @(negedge clk);
                end
                in_valid = 1'b0;
            end
            begin
                if (d == 0) step();
                for (int t = 0; t < n * 4; t++) begin
                    wait_tick();
                    check("R2 R3 R4 R8 slot order", 32'(out_sample), slot8(t));
                end
                check("R7 no underrun while fed", 32'(underrun), 32'h0);
                wait_tick();
                check("R7 holds last sample", 32'(out_sample), slot8(n * 4 - 1));
                check("R7 underrun raised", 32'(underrun), 32'h1);
            end
        join
        if (resume) begin
            in_valid = 1'b1; in_word = 32'h0000_00A5;
            step();
            in_valid = 1'b0;
            wait_tick();
            check("R7 resumes with new word", 32'(out_sample), 32'hA5);
            check("R7 underrun stays set", 32'(underrun), 32'h1);
        end
    endtask

    // R5: queue limit per mode, a word offered while full is discarded.
    task automatic t_capacity(input bit j);
        int cap;
        cap = j ? 8 : 4;
        do_reset(40, j);
        for (int i = 0; i < cap; i++) begin
            wq[i] = 32'h1020_3040 + 32'(i * 32'h0101_0101);
            check("R5 ready below limit", 32'(in_ready), 32'h1);
            in_valid = 1'b1; in_word = wq[i];
            step();
        end
        check("R5 not ready at limit", 32'(in_ready), 32'h0);
        in_word = 32'hDEAD_BEEF;
        step(); step();
        in_valid = 1'b0;
        for (int t = 0; t < cap * 4; t++) begin
            wait_tick();
            check("R5 stored words in order", 32'(out_sample), slot8(t));
        end
        wait_tick();
        check("R5 extra word was dropped", 32'(underrun), 32'h1);
        check("R5 output holds", 32'(out_sample), slot8(cap * 4 - 1));
    endtask

    // R6: maximum divide value, first tick at edge 65535.
    task automatic t_div_max();
        do_reset(65535, 1'b0);
        in_valid = 1'b1; in_word = 32'h0000_005C;
        step();
        in_valid = 1'b0;
        while (ecount < 65534) step();
        check("R6 no tick before edge 65535", 32'(out_sample), 32'h0);
        step();
        check("R6 tick at edge 65535", 32'(out_sample), 32'h5C);
    endtask

    // R1 R8: 10-bit slots, three per word, top two bits dropped.
    task automatic t_w10();
        logic [31:0] w10 [3];
        w10[0] = 32'hC00F_FC01; w10[1] = 32'h8ABC_DEF5; w10[2] = 32'hFFFF_FFFF;
        do_reset(0, 1'b0);
        fork
            begin
                for (int i = 0; i < 3; i++) begin
                    in10_valid = 1'b1; in10_word = w10[i];
                    @(posedge clk); @(negedge clk);
                end
                in10_valid = 1'b0;
            end
            begin
                step();
                for (int t = 0; t < 9; t++) begin
                    wait_tick();
                    check("R1 R8 ten-bit slot", 32'(out10),
                          (w10[t / 3] >> (10 * (t % 3))) & 32'h3FF);
                end
                wait_tick();
                check("R1 leftover bits never sent", 32'(out10), 32'h3FF);
                check("R7 ten-bit underrun", 32'(und10), 32'h1);
            end
        join
    endtask

    initial begin
        t_reset();
        wq[0] = 32'h4433_2211; wq[1] = 32'h8877_6655; wq[2] = 32'hFFEE_DDCC;
        t_stream(0, 3, 1'b0);
        wq[0] = 32'h0102_0304; wq[1] = 32'hA0B0_C0D0; wq[2] = 32'h7F80_01FE;
        wq[3] = 32'h5A5A_A5A5;
        t_stream(2, 4, 1'b1);
        t_capacity(1'b0);
        t_capacity(1'b1);
        t_w10();
        t_div_max();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule